// File: doc/BRIEF.md
# Mixed-radix BCD time counter

This block keeps a running time in the form M:SS:hh, from 0:00:00 up to 9:59:99, as five 4-bit BCD digits. Every digit steps in decimal except tens of seconds, which steps in base six. One count equals one hundredth of a second. The count moves only when a one-cycle tick from an external divider and a level enable are both high. A direction input picks up or down counting.

The surrounding logic can clear the count to zero or load a 20-bit preset at any time. A preset digit above its own maximum is clamped to that maximum. The count saturates at both ends. An up step at 9:59:99 does nothing. A down step at 0:00:00 also does nothing, but it raises a terminal flag for one cycle, so a countdown timer can detect expiry.

Top module: `bcd_time_counter`

## Requirements
- R1: While rst_ni is low, all five digits are 0 and term_o is 0.
- R2: A step is a cycle with enable_i and tick_i both high. An up step (down_i = 0) adds one hundredth. The hundredths, tenths, seconds and minutes digits wrap 9 to 0 and carry into the next digit.
- R3: The tens-of-seconds digit wraps 5 to 0 on an up carry, so 0:59:99 steps to 1:00:00.
- R4: A down step (down_i = 1) subtracts one hundredth. The tens-of-seconds digit borrows 0 to 5 and every other digit borrows 0 to 9, so 1:00:00 steps to 0:59:99.
- R5: An up step at 9:59:99 leaves the count at 9:59:99 and keeps term_o at 0.
- R6: A down step at 0:00:00 leaves the count at zero. term_o is 1 in the cycle after that step only, and it is 0 at all other times.
- R7: clear_i forces every digit to 0 on the next edge. It wins over load_i and over a step, and it drops term_o.
- R8: load_i without clear_i copies preset_i on the next edge, even if a step falls in the same cycle. The fields are minutes [19:16], tens of seconds [15:12], seconds [11:8], tenths [7:4] and hundredths [3:0].
- R9: A preset field above its digit's maximum is loaded as that maximum. The maximum is 5 for tens of seconds and 9 for every other digit.
- R10: With no clear and no load, the count stays unchanged in any cycle where enable_i or tick_i is low.
- R11: After reset, every digit always lies within its radix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear to 0:00:00 |
| load_i | input | 1 | Load preset_i |
| preset_i | input | 20 | Preset digits, minutes in the top nibble |
| enable_i | input | 1 | Counting enable |
| tick_i | input | 1 | 1/100 s tick pulse |
| down_i | input | 1 | 1 = count down, 0 = count up |
| minutes_o | output | 4 | Minutes digit |
| sec_tens_o | output | 4 | Tens-of-seconds digit |
| sec_ones_o | output | 4 | Seconds digit |
| tenths_o | output | 4 | Tenths digit |
| hundredths_o | output | 4 | Hundredths digit |
| term_o | output | 1 | One-cycle flag for a down step at zero |

## Verification
Two functions can collide in one cycle: a clear or a load, and a counting step. The bench raises clear_i, load_i, enable_i and tick_i in the same cycle and expects zero. It then raises load_i together with an up step and expects exactly the preset, with no extra hundredth added. The same idea applies at the ends of the range: a step that would pass zero in the down direction must both hold the count and raise term_o, and the bench checks the flag in the following cycle and again one cycle later.

// File: rtl/bcd_time_pkg.sv
package bcd_time_pkg;
  localparam int unsigned DIGIT_W    = 4;
  localparam int unsigned NUM_DIGITS = 5;
  localparam int unsigned TIME_W     = DIGIT_W * NUM_DIGITS;
  localparam int unsigned SEC_TENS_IDX = 3;

  typedef logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digits_t;

  // index 0 = hundredths ... index 4 = minutes
  function automatic int unsigned digit_max(int unsigned idx);
    return (idx == SEC_TENS_IDX) ? 5 : 9;
  endfunction
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned MAX_VAL = 9
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             up_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] nxt_o,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] MaxV = WIDTH'(MAX_VAL);

  logic at_top, at_bot;
  assign at_top = (cur_i >= MaxV);
  assign at_bot = (cur_i == '0);

  assign carry_o = carry_i & (up_i ? at_top : at_bot);

  always_comb begin
    nxt_o = cur_i;
    if (carry_i) begin
      if (up_i) nxt_o = at_top ? '0 : cur_i + 1'b1;
      else      nxt_o = at_bot ? MaxV : cur_i - 1'b1;
    end
  end
endmodule

// File: rtl/bcd_preset_clamp.sv
module bcd_preset_clamp
  import bcd_time_pkg::*;
(
  input  logic [TIME_W-1:0] preset_i,
  output digits_t           clamped_o
);
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_clamp
    localparam logic [DIGIT_W-1:0] MaxV = DIGIT_W'(digit_max(g));
    logic [DIGIT_W-1:0] field;
    assign field        = preset_i[g*DIGIT_W +: DIGIT_W];
    assign clamped_o[g] = (field > MaxV) ? MaxV : field;
  end
endmodule

// File: rtl/bcd_time_counter.sv
module bcd_time_counter
  import bcd_time_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] preset_i,
  input  logic              enable_i,
  input  logic              tick_i,
  input  logic              down_i,
  output logic [DIGIT_W-1:0] minutes_o,
  output logic [DIGIT_W-1:0] sec_tens_o,
  output logic [DIGIT_W-1:0] sec_ones_o,
  output logic [DIGIT_W-1:0] tenths_o,
  output logic [DIGIT_W-1:0] hundredths_o,
  output logic              term_o
);
  digits_t cnt_q, cnt_nxt, preset_c;
  logic [NUM_DIGITS:0] chain;
  logic step, sat, term_q;

  assign step     = enable_i & tick_i;
  assign chain[0] = step;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
    bcd_digit_cell #(
      .WIDTH  (DIGIT_W),
      .MAX_VAL(digit_max(g))
    ) u_cell (
      .cur_i  (cnt_q[g]),
      .up_i   (~down_i),
      .carry_i(chain[g]),
      .nxt_o  (cnt_nxt[g]),
      .carry_o(chain[g+1])
    );
  end

  // carry out of the top digit means every digit sits at its end value
  assign sat = chain[NUM_DIGITS];

  bcd_preset_clamp u_clamp (
    .preset_i (preset_i),
    .clamped_o(preset_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      term_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      term_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= preset_c;
      term_q <= 1'b0;
    end else begin
      if (!sat) cnt_q <= cnt_nxt;
      term_q <= sat & down_i;
    end
  end

  assign minutes_o    = cnt_q[4];
  assign sec_tens_o   = cnt_q[3];
  assign sec_ones_o   = cnt_q[2];
  assign tenths_o     = cnt_q[1];
  assign hundredths_o = cnt_q[0];
  assign term_o       = term_q;
endmodule

// File: rtl/bcd_time_counter_chk.sv
module bcd_time_counter_chk
  import bcd_time_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              load_i,
  input logic [TIME_W-1:0] preset_i,
  input logic              enable_i,
  input logic              tick_i,
  input logic              down_i,
  input logic [DIGIT_W-1:0] minutes_o,
  input logic [DIGIT_W-1:0] sec_tens_o,
  input logic [DIGIT_W-1:0] sec_ones_o,
  input logic [DIGIT_W-1:0] tenths_o,
  input logic [DIGIT_W-1:0] hundredths_o,
  input logic              term_o
);
  logic [TIME_W-1:0] shown;
  assign shown = {minutes_o, sec_tens_o, sec_ones_o, tenths_o, hundredths_o};

  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (shown == '0) && !term_o);

  p_load_value_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i) |=>
      (sec_ones_o == ($past(preset_i[11:8]) > 4'd9 ? 4'd9 : $past(preset_i[11:8]))) &&
      (hundredths_o == ($past(preset_i[3:0]) > 4'd9 ? 4'd9 : $past(preset_i[3:0]))));

  p_load_clamp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i) |=>
      (sec_tens_o == ($past(preset_i[15:12]) > 4'd5 ? 4'd5 : $past(preset_i[15:12]))) &&
      (minutes_o == ($past(preset_i[19:16]) > 4'd9 ? 4'd9 : $past(preset_i[19:16]))));

  p_idle_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !load_i && !(enable_i && tick_i)) |=> $stable(shown));

  p_top_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !load_i && enable_i && tick_i && !down_i && shown == 20'h95999)
      |=> (shown == 20'h95999) && !term_o);

  p_term_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |-> (shown == '0) && $past(enable_i && tick_i && down_i && !clear_i && !load_i));

  p_digit_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (minutes_o <= 4'd9) && (sec_tens_o <= 4'd5) && (sec_ones_o <= 4'd9) &&
    (tenths_o <= 4'd9) && (hundredths_o <= 4'd9));
endmodule

bind bcd_time_counter bcd_time_counter_chk chk_i (.*);

// File: tb/bcd_time_counter_tb_top.sv
module bcd_time_counter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0, load_i = 1'b0, enable_i = 1'b0, tick_i = 1'b0, down_i = 1'b0;
  logic [19:0] preset_i = '0;
  logic [3:0]  minutes_o, sec_tens_o, sec_ones_o, tenths_o, hundredths_o;
  logic        term_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  bcd_time_counter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .load_i(load_i),
    .preset_i(preset_i), .enable_i(enable_i), .tick_i(tick_i), .down_i(down_i),
    .minutes_o(minutes_o), .sec_tens_o(sec_tens_o), .sec_ones_o(sec_ones_o),
    .tenths_o(tenths_o), .hundredths_o(hundredths_o), .term_o(term_o)
  );

  function automatic logic [19:0] shown();
    return {minutes_o, sec_tens_o, sec_ones_o, tenths_o, hundredths_o};
  endfunction

  function automatic int to_cs(logic [19:0] v);
    return v[19:16]*6000 + v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
  endfunction

  function automatic logic [19:0] from_cs(int cs);
    logic [19:0] r;
    r[19:16] = 4'(cs / 6000);
    r[15:12] = 4'((cs % 6000) / 1000);
    r[11:8]  = 4'((cs % 1000) / 100);
    r[7:4]   = 4'((cs % 100) / 10);
    r[3:0]   = 4'(cs % 10);
    return r;
  endfunction

  task automatic cycle();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk_time(string req, logic [19:0] exp);
    checks++;
    if (shown() !== exp) begin
      errors++;
      $display("FAIL %s: time actual %h expected %h", req, shown(), exp);
    end
  endtask

  task automatic chk_term(string req, logic exp);
    checks++;
    if (term_o !== exp) begin
      errors++;
      $display("FAIL %s: term_o actual %b expected %b", req, term_o, exp);
    end
  endtask

  task automatic load(logic [19:0] v);
    preset_i = v; load_i = 1'b1;
    cycle();
    load_i = 1'b0;
  endtask

  task automatic step(logic dn);
    down_i = dn; enable_i = 1'b1; tick_i = 1'b1;
    cycle();
    enable_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic t_reset_r1();
    chk_time("R1", 20'h00000);
    chk_term("R1", 1'b0);
  endtask

  task automatic t_up_decimal_r2();
    load(20'h00009); step(1'b0); chk_time("R2", 20'h00010);
    load(20'h00999); step(1'b0); chk_time("R2", 20'h01000);
    load(20'h00095);
    for (int i = 0; i < 10; i++) step(1'b0);
    chk_time("R2", from_cs(to_cs(20'h00095) + 10));
  endtask

  task automatic t_sec_tens_r3();
    load(20'h05999); step(1'b0); chk_time("R3", 20'h10000);
    load(20'h35999); step(1'b0); chk_time("R3", 20'h40000);
  endtask

  task automatic t_down_r4();
    load(20'h10000); step(1'b1); chk_time("R4", 20'h05999);
    load(20'h00010); step(1'b1); chk_time("R4", 20'h00009);
    load(20'h10020);
    for (int i = 0; i < 150; i++) step(1'b1);
    chk_time("R4", from_cs(to_cs(20'h10020) - 150));
  endtask

  task automatic t_top_r5();
    load(20'h95999); step(1'b0);
    chk_time("R5", 20'h95999);
    chk_term("R5", 1'b0);
    load(20'h95998); step(1'b0); step(1'b0);
    chk_time("R5", 20'h95999);
  endtask

  task automatic t_zero_r6();
    load(20'h00001); step(1'b1);
    chk_time("R6", 20'h00000);
    chk_term("R6", 1'b0);
    step(1'b1);
    chk_time("R6", 20'h00000);
    chk_term("R6", 1'b1);
    cycle();
    chk_term("R6", 1'b0);
  endtask

  task automatic t_clear_r7();
    load(20'h34567);
    clear_i = 1'b1; load_i = 1'b1; preset_i = 20'h12345;
    enable_i = 1'b1; tick_i = 1'b1; down_i = 1'b0;
    cycle();
    clear_i = 1'b0; load_i = 1'b0; enable_i = 1'b0; tick_i = 1'b0;
    chk_time("R7", 20'h00000);
    step(1'b1);
    clear_i = 1'b1;
    cycle();
    clear_i = 1'b0;
    chk_term("R7", 1'b0);
  endtask

  task automatic t_load_r8();
    preset_i = 20'h24318; load_i = 1'b1;
    enable_i = 1'b1; tick_i = 1'b1; down_i = 1'b0;
    cycle();
    load_i = 1'b0; enable_i = 1'b0; tick_i = 1'b0;
    chk_time("R8", 20'h24318);
  endtask

  task automatic t_clamp_r9();
    load(20'hF7CAB); chk_time("R9", 20'h95999);
    load(20'h16042); chk_time("R9", 20'h15042);
  endtask

  task automatic t_gate_r10();
    load(20'h40404);
    enable_i = 1'b1; tick_i = 1'b0; cycle(); enable_i = 1'b0;
    chk_time("R10", 20'h40404);
    tick_i = 1'b1; cycle(); tick_i = 1'b0;
    chk_time("R10", 20'h40404);
    down_i = 1'b1; cycle(); cycle();
    chk_time("R10", 20'h40404);
  endtask

  task automatic t_range_r11();
    load(20'h05990);
    for (int i = 0; i < 25; i++) step(1'b0);
    chk_time("R11", from_cs(to_cs(20'h05990) + 25));
    checks++;
    if (sec_tens_o > 4'd5) begin
      errors++;
      $display("FAIL R11: sec_tens actual %0d expected <= 5", sec_tens_o);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset_r1();
    rst_ni = 1'b1;
    cycle();
    t_up_decimal_r2();
    t_sec_tens_r3();
    t_down_r4();
    t_top_r5();
    t_zero_r6();
    t_clear_r7();
    t_load_r8();
    t_clamp_r9();
    t_gate_r10();
    t_range_r11();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule